// File: doc/BRIEF.md
# Two-Operand BCD Calculator Datapath

This block is the data side of a small decimal calculator. Two operands of up to two decimal digits each are typed in one digit at a time. Each keyed digit is pushed into the low end of an operand register, and the older digit moves up one place. An operation code is latched from the same key input. On a result strobe, the block does the following:

- converts both operands from BCD to binary,
- adds, subtracts or multiplies them,
- converts the binary answer back to four BCD digits,
- stores those digits in a result register.

A two-bit display select routes one of the stored values to a 16-bit output of four BCD digits.

All sequencing comes from outside. An external controller raises the load strobes, the clear and the display select. Keypad scanning and segment decoding sit outside the block as well. Reset is synchronous and active low. Clear is a synchronous, active-high request that has the same effect as reset.

Top module: `bcd_calc_datapath`

## Requirements
- R1: While rst_n is low at a rising clock edge, operand A, operand B, the operation code and the result all become zero, so every display select shows 0000.
- R2: A rising edge with clear_i high zeroes operand A, operand B, the operation code and the result.
- R3: A rising edge with ld_a_i high moves operand A's low digit (bits 3:0) into its high digit (bits 7:4) and places key_i in the low digit. Only the two most recent digits are kept.
- R4: ld_b_i loads operand B in the same digit-shifting way as R3.
- R5: A rising edge with ld_op_i high stores key_i as the operation code. A later result strobe uses the stored code, not the code present on key_i at that time.
- R6: With operation code 4'hF, a result strobe stores A + B as four BCD digits. Every stored digit is 0 to 9.
- R7: With operation code 4'hE, a result strobe stores A − B when A ≥ B, and 0000 when A < B.
- R8: With operation code 4'hD, a result strobe stores A × B. For example, 99 × 99 gives 9801.
- R9: Any operation code other than 4'hF, 4'hE or 4'hD makes a result strobe store 0000.
- R10: The result register changes only on a rising edge with ld_r_i, clear_i or reset active. Changes to the operands and the operation code do not reach the result until the next ld_r_i.
- R11: disp_o shows the following for each value of disp_sel_i. The upper two digits are 0 when an operand is shown.

| disp_sel_i | disp_o |
|---|---|
| 2'b00 | operand A |
| 2'b01 | operand B |
| 2'b10 | result |
| 2'b11 | 0000 |

- R12: Reset and clear override every load strobe asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all registers |
| ld_a_i | input | 1 | Shift key_i into operand A |
| ld_b_i | input | 1 | Shift key_i into operand B |
| ld_op_i | input | 1 | Store key_i as the operation code |
| ld_r_i | input | 1 | Compute and store the result |
| key_i | input | 4 | Key value: a BCD digit or an operation code |
| disp_sel_i | input | 2 | Display source select |
| disp_o | output | 16 | Four BCD digits for the display |

## Verification
The bench builds the block with its default parameters: 4-bit digits, two-digit operands and a four-digit result. At these values every reachable operand pair can be reached by typing digits, up to 99 × 99 = 9801 in the top result digit. Directed sequences cover the following:

- three-digit overflow of an operand entry,
- subtraction that would underflow,
- an unused operation code,
- operation changes that have not yet been committed to the result,
- clear and reset arriving together with every strobe.

A long pseudo-random phase follows. An integer model in the bench is compared against the output for the selected value on every cycle.

// File: rtl/calc_pkg.sv
// Package: shared constants for the BCD calculator datapath.
// Assumes 4-bit operation codes and a 2-bit display select.
package calc_pkg;
    localparam logic [3:0] OP_ADD = 4'hF;
    localparam logic [3:0] OP_SUB = 4'hE;
    localparam logic [3:0] OP_MUL = 4'hD;

    typedef enum logic [1:0] {
        SHOW_A   = 2'b00,
        SHOW_B   = 2'b01,
        SHOW_RES = 2'b10,
        SHOW_NUL = 2'b11
    } show_sel_t;

    // True when the code is one of the three supported operations.
    function automatic logic op_is_valid(input logic [3:0] code);
        return (code == OP_ADD) || (code == OP_SUB) || (code == OP_MUL);
    endfunction
endpackage

// File: rtl/digit_shift_reg.sv
// digit_shift_reg: holds DIGITS decimal digits. On a load, every digit moves up
// one place and the new digit enters the least significant position.
// Assumes: synchronous active-low reset; clear and reset beat the load.
module digit_shift_reg #(
    parameter int DIGIT_W = 4,
    parameter int DIGITS  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic                      ld_i,
    input  logic [DIGIT_W-1:0]        din_i,
    output logic [DIGIT_W*DIGITS-1:0] q_o
);
    localparam int W = DIGIT_W * DIGITS;

    logic [W-1:0] q;

    generate
        if (DIGITS > 1) begin : g_multi
            // Shift a new digit in at the low end; clear/reset take priority.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) q <= '0;
                else if (ld_i)       q <= {q[W-DIGIT_W-1:0], din_i};
            end

            // R3
            upper_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ld_i && !clr_i) |=> (q[2*DIGIT_W-1:DIGIT_W] == $past(q[DIGIT_W-1:0])));
        end else begin : g_single
            // Single-digit variant: a load simply replaces the digit.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) q <= '0;
                else if (ld_i)       q <= din_i;
            end
        end
    endgenerate

    // R3
    low_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && !clr_i) |=> (q[DIGIT_W-1:0] == $past(din_i)));

    assign q_o = q;
endmodule

// File: rtl/bcd_to_bin.sv
// bcd_to_bin: converts a packed BCD number (most significant digit first) to
// binary by repeated multiply-by-ten and add. Assumes each digit is 0..9.
module bcd_to_bin #(
    parameter int DIGITS = 2,
    parameter int BIN_W  = 7
) (
    input  logic [4*DIGITS-1:0] bcd_i,
    output logic [BIN_W-1:0]    bin_o
);
    // Horner evaluation over the digits, high digit first.
    always_comb begin
        bin_o = '0;
        for (int d = DIGITS - 1; d >= 0; d--) begin
            bin_o = bin_o * BIN_W'(10) + BIN_W'(bcd_i[d*4 +: 4]);
        end
    end
endmodule

// File: rtl/bin_to_bcd.sv
// bin_to_bcd: shift-and-add-3 conversion of a binary value to DIGITS BCD
// digits. Assumes the input is below 10**DIGITS.
module bin_to_bcd #(
    parameter int BIN_W  = 14,
    parameter int DIGITS = 4
) (
    input  logic [BIN_W-1:0]    bin_i,
    output logic [4*DIGITS-1:0] bcd_o
);
    localparam int BCD_W = 4 * DIGITS;

    // Per input bit: correct each digit that is five or more, then shift the bit in.
    always_comb begin
        bcd_o = '0;
        for (int i = BIN_W - 1; i >= 0; i--) begin
            for (int d = 0; d < DIGITS; d++) begin
                if (bcd_o[d*4 +: 4] >= 4'd5)
                    bcd_o[d*4 +: 4] = bcd_o[d*4 +: 4] + 4'd3;
            end
            bcd_o = {bcd_o[BCD_W-2:0], bin_i[i]};
        end
    end
endmodule

// File: rtl/calc_arith.sv
// calc_arith: binary add, saturating subtract or multiply, chosen by a 4-bit
// operation code. Unknown codes give zero. Assumes the result width holds
// the largest product.
module calc_arith #(
    parameter int IN_W  = 7,
    parameter int OUT_W = 14
) (
    input  logic [IN_W-1:0]  a_i,
    input  logic [IN_W-1:0]  b_i,
    input  logic [3:0]       op_i,
    output logic [OUT_W-1:0] y_o
);
    import calc_pkg::*;

    logic [OUT_W-1:0] a_x, b_x;

    assign a_x = OUT_W'(a_i);
    assign b_x = OUT_W'(b_i);

    // Select the operation; subtraction is clamped at zero.
    always_comb begin
        unique case (op_i)
            OP_ADD:  y_o = a_x + b_x;
            OP_SUB:  y_o = (a_x >= b_x) ? (a_x - b_x) : '0;
            OP_MUL:  y_o = a_x * b_x;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/bcd_calc_datapath.sv
// bcd_calc_datapath: two digit-shifting BCD operand registers, an operation
// register, a converted-arithmetic path and a BCD result register, plus a
// display selector. Assumes an external controller drives every strobe;
// reset is synchronous active low, and clear and reset beat all loads.
module bcd_calc_datapath #(
    parameter int OPND_DIGITS = 2,
    parameter int RES_DIGITS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    ld_a_i,
    input  logic                    ld_b_i,
    input  logic                    ld_op_i,
    input  logic                    ld_r_i,
    input  logic [3:0]              key_i,
    input  logic [1:0]              disp_sel_i,
    output logic [4*RES_DIGITS-1:0] disp_o
);
    import calc_pkg::*;

    localparam int OPND_W     = 4 * OPND_DIGITS;
    localparam int DISP_W     = 4 * RES_DIGITS;
    localparam int OPND_BIN_W = $clog2(10 ** OPND_DIGITS);
    localparam int RES_BIN_W  = $clog2(10 ** RES_DIGITS);
    localparam int N_OPND     = 2;

    logic [OPND_W-1:0]     opnd_q   [N_OPND];
    logic [OPND_BIN_W-1:0] opnd_bin [N_OPND];
    logic [N_OPND-1:0]     opnd_ld;
    logic [3:0]            op_q;
    logic [RES_BIN_W-1:0]  res_bin;
    logic [DISP_W-1:0]     res_bcd;
    logic [DISP_W-1:0]     res_q;

    assign opnd_ld = {ld_b_i, ld_a_i};

    // One storage-and-conversion lane per operand (index 0 = A, 1 = B).
    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
        digit_shift_reg #(.DIGIT_W(4), .DIGITS(OPND_DIGITS)) u_sreg (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clear_i),
            .ld_i  (opnd_ld[k]),
            .din_i (key_i),
            .q_o   (opnd_q[k])
        );
        bcd_to_bin #(.DIGITS(OPND_DIGITS), .BIN_W(OPND_BIN_W)) u_tobin (
            .bcd_i (opnd_q[k]),
            .bin_o (opnd_bin[k])
        );
    end

    calc_arith #(.IN_W(OPND_BIN_W), .OUT_W(RES_BIN_W)) u_arith (
        .a_i  (opnd_bin[0]),
        .b_i  (opnd_bin[1]),
        .op_i (op_q),
        .y_o  (res_bin)
    );

    bin_to_bcd #(.BIN_W(RES_BIN_W), .DIGITS(RES_DIGITS)) u_tobcd (
        .bin_i (res_bin),
        .bcd_o (res_bcd)
    );

    // Operation code register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) op_q <= '0;
        else if (ld_op_i)      op_q <= key_i;
    end

    // Result register, written only on the result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) res_q <= '0;
        else if (ld_r_i)       res_q <= res_bcd;
    end

    // Display source selector with operand zero-extension.
    always_comb begin
        unique case (show_sel_t'(disp_sel_i))
            SHOW_A:   disp_o = DISP_W'(opnd_q[0]);
            SHOW_B:   disp_o = DISP_W'(opnd_q[1]);
            SHOW_RES: disp_o = res_q;
            default:  disp_o = '0;
        endcase
    end

    // R2
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (opnd_q[0] == '0 && opnd_q[1] == '0 && op_q == '0 && res_q == '0));

    // R5
    op_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_op_i && !clear_i) |=> (op_q == $past(key_i)));

    // R10
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_r_i && !clear_i) |=> (res_q == $past(res_q)));

    // R9
    bad_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_r_i && !clear_i && !op_is_valid(op_q)) |=> (res_q == '0));

    // R7
    sub_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_r_i && !clear_i && op_q == OP_SUB && opnd_bin[0] < opnd_bin[1]) |=> (res_q == '0));

    // R6
    for (genvar d = 0; d < RES_DIGITS; d++) begin : g_digit_chk
        res_digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ld_r_i |=> (res_q[d*4 +: 4] <= 4'd9));
    end
endmodule

// File: tb/test_bcd_calc_datapath.sv
`timescale 1ns/1ps
module test_bcd_calc_datapath;
    logic        clk = 1'b0;
    logic        rst_n, clear_i, ld_a_i, ld_b_i, ld_op_i, ld_r_i;
    logic [3:0]  key_i;
    logic [1:0]  disp_sel_i;
    logic [15:0] disp_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Behavioural model state, decimal integers.
    int m_a = 0, m_b = 0, m_op = 0, m_r = 0;

    always #2 clk = ~clk;

    bcd_calc_datapath i_bcd_calc_datapath (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .ld_a_i(ld_a_i),
        .ld_b_i(ld_b_i), .ld_op_i(ld_op_i), .ld_r_i(ld_r_i), .key_i(key_i),
        .disp_sel_i(disp_sel_i), .disp_o(disp_o)
    );

    function automatic logic [15:0] to_bcd(input int v);
        return {4'((v / 1000) % 10), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic int compute(input int a, input int b, input int op);
        if (op == 15) return a + b;
        if (op == 14) return (a >= b) ? a - b : 0;
        if (op == 13) return a * b;
        return 0;
    endfunction

    function automatic logic [15:0] model_disp(input logic [1:0] sel);
        case (sel)
            2'b00:   return to_bcd(m_a);
            2'b01:   return to_bcd(m_b);
            2'b10:   return to_bcd(m_r);
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare 1 ns later.
    task automatic step(input logic rn, input logic clr, input logic la, input logic lb,
                        input logic lop, input logic lr, input logic [3:0] key,
                        input logic [1:0] sel, input string tag);
        int nr;
        @(negedge clk);
        rst_n = rn; clear_i = clr; ld_a_i = la; ld_b_i = lb;
        ld_op_i = lop; ld_r_i = lr; key_i = key; disp_sel_i = sel;
        @(posedge clk);
        if (!rn || clr) begin
            m_a = 0; m_b = 0; m_op = 0; m_r = 0;
        end else begin
            nr = lr ? compute(m_a, m_b, m_op) : m_r;
            if (la)  m_a = (m_a % 10) * 10 + int'(key);
            if (lb)  m_b = (m_b % 10) * 10 + int'(key);
            if (lop) m_op = int'(key);
            m_r = nr;
        end
        #1;
        check(tag, disp_o, model_disp(sel));
    endtask

    // Idle cycle showing one source, also compared with a fixed value.
    task automatic show(input logic [1:0] sel, input logic [15:0] exp, input string tag);
        step(1, 0, 0, 0, 0, 0, 4'h0, sel, tag);
        check(tag, disp_o, exp);
    endtask

    task automatic key_a(input int d);
        step(1, 0, 1, 0, 0, 0, 4'(d), 2'b00, "R3");
    endtask

    task automatic key_b(input int d);
        step(1, 0, 0, 1, 0, 0, 4'(d), 2'b01, "R4");
    endtask

    task automatic set_op(input logic [3:0] c);
        step(1, 0, 0, 0, 1, 0, c, 2'b10, "R5");
    endtask

    task automatic exec_r;
        step(1, 0, 0, 0, 0, 1, 4'h0, 2'b10, "R10");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; clear_i = 0; ld_a_i = 0; ld_b_i = 0; ld_op_i = 0; ld_r_i = 0;
        key_i = 0; disp_sel_i = 0;
        // R12: reset with every strobe raised
        step(0, 0, 1, 1, 1, 1, 4'h7, 2'b00, "R12");
        step(0, 0, 1, 1, 1, 1, 4'h7, 2'b01, "R12");
        // R1: reset state on every select
        show(2'b00, 16'h0000, "R1");
        show(2'b01, 16'h0000, "R1");
        show(2'b10, 16'h0000, "R1");
        show(2'b11, 16'h0000, "R1");
        // R3: two digits, then a third pushes the oldest out
        key_a(4); key_a(7);
        show(2'b00, 16'h0047, "R3");
        key_a(1); key_a(2); key_a(3);
        show(2'b00, 16'h0023, "R3");
        // R4 and R6: 23 + 25
        key_b(2); key_b(5);
        show(2'b01, 16'h0025, "R4");
        set_op(4'hF);
        exec_r;
        show(2'b10, 16'h0048, "R6");
        // R11: unused select shows zero while values are nonzero
        show(2'b11, 16'h0000, "R11");
        // R10: change operands and op without a strobe; result unchanged
        key_a(9); key_a(9); key_b(9); key_b(9); set_op(4'hD);
        show(2'b10, 16'h0048, "R10");
        // R8: 99 x 99
        exec_r;
        show(2'b10, 16'h9801, "R8");
        // R6: carry across digits, 99 + 99
        set_op(4'hF); exec_r;
        show(2'b10, 16'h0198, "R6");
        // R2 and R12: clear beats simultaneous loads
        step(1, 1, 1, 1, 1, 1, 4'h5, 2'b00, "R12");
        show(2'b00, 16'h0000, "R2");
        show(2'b01, 16'h0000, "R2");
        show(2'b10, 16'h0000, "R2");
        // R7: 12 - 34 saturates, then 90 - 34
        key_a(1); key_a(2); key_b(3); key_b(4); set_op(4'hE); exec_r;
        show(2'b10, 16'h0000, "R7");
        key_a(9); key_a(0); exec_r;
        show(2'b10, 16'h0056, "R7");
        // R5: op on key_i at strobe time is not used
        step(1, 0, 0, 0, 0, 1, 4'hD, 2'b10, "R5");
        show(2'b10, 16'h0056, "R5");
        // R9: unused operation code
        set_op(4'hA); exec_r;
        show(2'b10, 16'h0000, "R9");
        set_op(4'h0); exec_r;
        show(2'b10, 16'h0000, "R9");
        // Pseudo-random phase compared against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            int p, q;
            logic rn, clr, la, lb, lop, lr;
            logic [3:0] k;
            p   = int'($urandom_range(0, 999));
            rn  = (p >= 5);
            clr = (p >= 5 && p < 25);
            lr  = ($urandom_range(0, 3) == 0);
            lop = ($urandom_range(0, 5) == 0);
            if (lop) begin
                la = 0; lb = 0;
                q  = int'($urandom_range(0, 7));
                k  = (q < 6) ? 4'(13 + q % 3) : 4'($urandom_range(0, 12));
            end else begin
                la = ($urandom_range(0, 2) == 0);
                lb = ($urandom_range(0, 2) == 0);
                k  = 4'($urandom_range(0, 9));
            end
            step(rn, clr, la, lb, lop, lr, k, 2'($urandom_range(0, 3)), "R10");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule